// File: doc/BRIEF.md
# Execution-Unit Result Staging Datapath

This block holds the data registers of the late execution stages: the ALU result and store operand captured in the second half of stage 2, the result and store registers of stage 3A, the stage 3B result, and the destination register C written in stage 4A. The control pipeline supplies the multiplexer selects. The ALU output, the store operand and the cache read data arrive as plain input ports. Every register advances only in its own half-cycle, chosen by a phase input that toggles each clock: low for an A phase, high for a B phase.

Two paths make this more than a shift chain. First, the stage 3A result and store registers can take the stage 3B result instead of the value from stage 2B. This replays a rejected access. Second, the stage 3B result can be taken from the cache read data in place of the ALU path. Source and destination register addresses arrive on the inbound half of a shared address bus during B phases. At write-back, a registered outbound data port with a valid strobe returns the result when the destination address falls inside a parameterised window. That window stands for the registers kept on the instruction-fetch side.

Top module: `exu_result_stage`

## Requirements
- R1: While reset is asserted, all data registers and captured addresses read zero and `wb_vld_o` is 0.
- R2: On a B-phase clock, `result2b_o` takes `alu_res_i` and the internal stage 2B store register takes `store_op_i`. On an A-phase clock both hold, whatever the ALU and store inputs are.
- R3: On an A-phase clock, `result3a_o` takes `result3b_o` when `sel_r3a_i` is 1, and `result2b_o` when it is 0. On a B-phase clock it holds, whatever the select is.
- R4: On an A-phase clock, `store3a_o` takes `result3b_o` when `sel_s3a_i` is 1, and the stage 2B store register when it is 0. On a B-phase clock it holds.
- R5: On a B-phase clock, `result3b_o` takes `cache_rdata_i` when `sel_r3b_i` is 1, and `result3a_o` when it is 0. On an A-phase clock it holds, whatever the select and cache data are.
- R6: On an A-phase clock, `creg_o` takes `result3b_o`. On a B-phase clock it holds.
- R7: On a B-phase clock with `kbus_ab_vld_i` high, `src_a_o` takes `kbus_i[ADDR_W-1:0]` and `src_b_o` takes `kbus_i[2*ADDR_W-1:ADDR_W]`. Otherwise both hold, including on an A-phase clock with the strobe high.
- R8: On a B-phase clock with `kbus_c_vld_i` high, `c_addr_o` takes `kbus_i[ADDR_W-1:0]`. Otherwise it holds, including on an A-phase clock with the strobe high.
- R9: On an A-phase clock, `wb_vld_o` becomes 1 and `wb_data_o` takes `result3b_o` when `WIN_BASE <= c_addr_o < WIN_BASE + WIN_COUNT` (default 96 to 111). Otherwise `wb_vld_o` becomes 0 and `wb_data_o` holds. On every B-phase clock `wb_vld_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_b_i | input | 1 | 1 = B phase, 0 = A phase |
| alu_res_i | input | DATA_W | ALU result for stage 2B |
| store_op_i | input | DATA_W | Store operand for stage 2B |
| sel_r3a_i | input | 1 | Stage 3A result source: 1 = 3B result, 0 = 2B result |
| sel_s3a_i | input | 1 | Stage 3A store source: 1 = 3B result, 0 = 2B store |
| sel_r3b_i | input | 1 | Stage 3B result source: 1 = cache data, 0 = 3A result |
| cache_rdata_i | input | DATA_W | Cache read data |
| kbus_i | input | 2*ADDR_W | Inbound shared address bus |
| kbus_ab_vld_i | input | 1 | Bus carries A (low) and B (high) source addresses |
| kbus_c_vld_i | input | 1 | Bus low field carries the C address |
| result2b_o | output | DATA_W | Stage 2B result |
| result3a_o | output | DATA_W | Stage 3A result |
| store3a_o | output | DATA_W | Stage 3A store data |
| result3b_o | output | DATA_W | Stage 3B result |
| creg_o | output | DATA_W | Destination register C |
| src_a_o | output | ADDR_W | Captured A source address |
| src_b_o | output | ADDR_W | Captured B source address |
| c_addr_o | output | ADDR_W | Captured C destination address |
| wb_data_o | output | DATA_W | Outbound write-back data |
| wb_vld_o | output | 1 | Outbound write-back valid |

## Verification
The hardest state to reach is a replay. There, stage 3A reloads from stage 3B while stage 3B has just taken cache data, so a later value flows backwards into an earlier register. The stimulus table reaches it by chaining phase pairs: one row selects cache data into 3B, and the following A phase selects 3B into 3A and the store register. It also drives every select and data input with deliberately wrong values during the phase that must ignore them. The write-back window is then probed on both sides of each edge (95, 96, 111, 112) through the C-address capture path.

// File: rtl/ers_pkg.sv
`timescale 1ns/1ps
package ers_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    function automatic logic in_window(input int unsigned addr,
                                       input int unsigned base,
                                       input int unsigned count);
        return (addr >= base) && (addr < base + count);
    endfunction

endpackage

// File: rtl/ers_addr_capture.sv
`timescale 1ns/1ps
module ers_addr_capture
    import ers_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  phase_e                phase,
    input  logic [2*ADDR_W-1:0]   bus,
    input  logic                  ab_vld,
    input  logic                  c_vld,
    output logic [ADDR_W-1:0]     src_a,
    output logic [ADDR_W-1:0]     src_b,
    output logic [ADDR_W-1:0]     c_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] src_a;
        logic [ADDR_W-1:0] src_b;
        logic [ADDR_W-1:0] c_addr;
    } addr_t;

    addr_t st_d, st_q;

    logic [ADDR_W-1:0] lo_field;
    logic [ADDR_W-1:0] hi_field;

    assign lo_field = bus[ADDR_W-1:0];
    assign hi_field = bus[2*ADDR_W-1:ADDR_W];

    always_comb begin
        st_d = st_q;
        if (phase == PH_B) begin
            if (ab_vld) begin
                st_d.src_a = lo_field;
                st_d.src_b = hi_field;
            end
            if (c_vld) begin
                st_d.c_addr = lo_field;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_a  = st_q.src_a;
    assign src_b  = st_q.src_b;
    assign c_addr = st_q.c_addr;

endmodule

// File: rtl/ers_result_pipe.sv
`timescale 1ns/1ps
module ers_result_pipe
    import ers_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] store_op,
    input  logic              sel_r3a,
    input  logic              sel_s3a,
    input  logic              sel_r3b,
    input  logic [DATA_W-1:0] cache_rdata,
    output logic [DATA_W-1:0] result2b,
    output logic [DATA_W-1:0] result3a,
    output logic [DATA_W-1:0] store3a,
    output logic [DATA_W-1:0] result3b
);

    typedef struct packed {
        logic [DATA_W-1:0] r2b;
        logic [DATA_W-1:0] s2b;
        logic [DATA_W-1:0] r3a;
        logic [DATA_W-1:0] s3a;
        logic [DATA_W-1:0] r3b;
    } pipe_t;

    pipe_t st_d, st_q;

    // Candidate sources, named for readability of the replay paths
    logic [DATA_W-1:0] r3a_src;
    logic [DATA_W-1:0] s3a_src;
    logic [DATA_W-1:0] r3b_src;

    always_comb begin
        r3a_src = sel_r3a ? st_q.r3b : st_q.r2b;
        s3a_src = sel_s3a ? st_q.r3b : st_q.s2b;
        r3b_src = sel_r3b ? cache_rdata : st_q.r3a;
    end

    always_comb begin
        st_d = st_q;
        unique case (phase)
            PH_B: begin
                st_d.r2b = alu_res;
                st_d.s2b = store_op;
                st_d.r3b = r3b_src;
            end
            PH_A: begin
                st_d.r3a = r3a_src;
                st_d.s3a = s3a_src;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result2b = st_q.r2b;
    assign result3a = st_q.r3a;
    assign store3a  = st_q.s3a;
    assign result3b = st_q.r3b;

endmodule

// File: rtl/ers_writeback.sv
`timescale 1ns/1ps
module ers_writeback
    import ers_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned WIN_BASE  = 96,
    parameter int unsigned WIN_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] result3b,
    input  logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] creg,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_vld
);

    typedef struct packed {
        logic [DATA_W-1:0] creg;
        logic [DATA_W-1:0] wb_data;
        logic              wb_vld;
    } wb_t;

    wb_t  st_d, st_q;
    logic hit;

    generate
        if (WIN_COUNT == 0) begin : g_no_window
            assign hit = 1'b0;
        end else begin : g_window
            assign hit = in_window(32'(c_addr), WIN_BASE, WIN_COUNT);
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.wb_vld = 1'b0;
        if (phase == PH_A) begin
            st_d.creg = result3b;
            if (hit) begin
                st_d.wb_data = result3b;
                st_d.wb_vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign creg    = st_q.creg;
    assign wb_data = st_q.wb_data;
    assign wb_vld  = st_q.wb_vld;

endmodule

// File: rtl/exu_result_stage.sv
`timescale 1ns/1ps
module exu_result_stage
    import ers_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned WIN_BASE  = 96,
    parameter int unsigned WIN_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phase_b_i,
    input  logic [DATA_W-1:0]   alu_res_i,
    input  logic [DATA_W-1:0]   store_op_i,
    input  logic                sel_r3a_i,
    input  logic                sel_s3a_i,
    input  logic                sel_r3b_i,
    input  logic [DATA_W-1:0]   cache_rdata_i,
    input  logic [2*ADDR_W-1:0] kbus_i,
    input  logic                kbus_ab_vld_i,
    input  logic                kbus_c_vld_i,
    output logic [DATA_W-1:0]   result2b_o,
    output logic [DATA_W-1:0]   result3a_o,
    output logic [DATA_W-1:0]   store3a_o,
    output logic [DATA_W-1:0]   result3b_o,
    output logic [DATA_W-1:0]   creg_o,
    output logic [ADDR_W-1:0]   src_a_o,
    output logic [ADDR_W-1:0]   src_b_o,
    output logic [ADDR_W-1:0]   c_addr_o,
    output logic [DATA_W-1:0]   wb_data_o,
    output logic                wb_vld_o
);

    phase_e phase;
    assign phase = phase_e'(phase_b_i);

    ers_addr_capture #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .bus    (kbus_i),
        .ab_vld (kbus_ab_vld_i),
        .c_vld  (kbus_c_vld_i),
        .src_a  (src_a_o),
        .src_b  (src_b_o),
        .c_addr (c_addr_o)
    );

    ers_result_pipe #(
        .DATA_W (DATA_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .alu_res     (alu_res_i),
        .store_op    (store_op_i),
        .sel_r3a     (sel_r3a_i),
        .sel_s3a     (sel_s3a_i),
        .sel_r3b     (sel_r3b_i),
        .cache_rdata (cache_rdata_i),
        .result2b    (result2b_o),
        .result3a    (result3a_o),
        .store3a     (store3a_o),
        .result3b    (result3b_o)
    );

    ers_writeback #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_COUNT (WIN_COUNT)
    ) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .result3b (result3b_o),
        .c_addr   (c_addr_o),
        .creg     (creg_o),
        .wb_data  (wb_data_o),
        .wb_vld   (wb_vld_o)
    );

endmodule

// File: rtl/ers_chk.sv
`timescale 1ns/1ps
module ers_chk #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned WIN_BASE  = 96,
    parameter int unsigned WIN_COUNT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase_b_i,
    input logic              sel_r3a_i,
    input logic              sel_r3b_i,
    input logic              kbus_ab_vld_i,
    input logic [DATA_W-1:0] cache_rdata_i,
    input logic [DATA_W-1:0] result2b_o,
    input logic [DATA_W-1:0] result3a_o,
    input logic [DATA_W-1:0] result3b_o,
    input logic [DATA_W-1:0] creg_o,
    input logic [ADDR_W-1:0] src_a_o,
    input logic [ADDR_W-1:0] src_b_o,
    input logic [ADDR_W-1:0] c_addr_o,
    input logic [DATA_W-1:0] wb_data_o,
    input logic              wb_vld_o
);

    AST_R2B_HOLD_IN_A: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_b_i |=> $stable(result2b_o)); // R2

    AST_R3A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_b_i |=> result3a_o == ($past(sel_r3a_i) ? $past(result3b_o) : $past(result2b_o))); // R3

    AST_R3B_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_b_i |=> result3b_o == ($past(sel_r3b_i) ? $past(cache_rdata_i) : $past(result3a_o))); // R5

    AST_C_FROM_R3B: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_b_i |=> creg_o == $past(result3b_o)); // R6

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_b_i && kbus_ab_vld_i) |=> ($stable(src_a_o) && $stable(src_b_o))); // R7

    AST_WB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld_o |-> (32'(c_addr_o) >= WIN_BASE) && (32'(c_addr_o) < WIN_BASE + WIN_COUNT)); // R9

    AST_WB_MATCHES_C: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld_o |-> wb_data_o == creg_o); // R9

    AST_WB_NOT_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
        phase_b_i |=> !wb_vld_o); // R9

endmodule

bind exu_result_stage ers_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_COUNT (WIN_COUNT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_b_i     (phase_b_i),
    .sel_r3a_i     (sel_r3a_i),
    .sel_r3b_i     (sel_r3b_i),
    .kbus_ab_vld_i (kbus_ab_vld_i),
    .cache_rdata_i (cache_rdata_i),
    .result2b_o    (result2b_o),
    .result3a_o    (result3a_o),
    .result3b_o    (result3b_o),
    .creg_o        (creg_o),
    .src_a_o       (src_a_o),
    .src_b_o       (src_b_o),
    .c_addr_o      (c_addr_o),
    .wb_data_o     (wb_data_o),
    .wb_vld_o      (wb_vld_o)
);

// File: tb/exu_result_stage_tb.sv
`timescale 1ns/1ps
module exu_result_stage_tb;

    localparam int DW = 32;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase_b = 1'b0;
    logic [DW-1:0] alu_res = '0, store_op = '0, cache_rdata = '0;
    logic          sel_r3a = 1'b0, sel_s3a = 1'b0, sel_r3b = 1'b0;
    logic [2*AW-1:0] kbus = '0;
    logic          ab_vld = 1'b0, c_vld = 1'b0;
    logic [DW-1:0] result2b, result3a, store3a, result3b, creg, wb_data;
    logic [AW-1:0] src_a, src_b, c_addr;
    logic          wb_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exu_result_stage u_dut (
        .clk(clk), .rst_n(rst_n), .phase_b_i(phase_b),
        .alu_res_i(alu_res), .store_op_i(store_op),
        .sel_r3a_i(sel_r3a), .sel_s3a_i(sel_s3a), .sel_r3b_i(sel_r3b),
        .cache_rdata_i(cache_rdata), .kbus_i(kbus),
        .kbus_ab_vld_i(ab_vld), .kbus_c_vld_i(c_vld),
        .result2b_o(result2b), .result3a_o(result3a), .store3a_o(store3a),
        .result3b_o(result3b), .creg_o(creg), .src_a_o(src_a), .src_b_o(src_b),
        .c_addr_o(c_addr), .wb_data_o(wb_data), .wb_vld_o(wb_vld)
    );

    typedef struct packed {
        logic [31:0] alu;
        logic [31:0] st;
        logic [31:0] cache;
        logic        sr3b;
        logic        sr3a;
        logic        ss3a;
        logic [31:0] e_r3a;
        logic [31:0] e_s3a;
        logic [31:0] e_r3b;
        logic [31:0] e_c;
    } vec_t;

    // One B phase then one A phase per row; expectations are the state after the A phase
    localparam vec_t VEC [7] = '{
        '{32'h11, 32'h21, 32'h31, 1'b0, 1'b0, 1'b0, 32'h11, 32'h21, 32'h00, 32'h00},
        '{32'h12, 32'h22, 32'h32, 1'b0, 1'b0, 1'b0, 32'h12, 32'h22, 32'h11, 32'h11},
        '{32'h13, 32'h23, 32'h33, 1'b1, 1'b1, 1'b0, 32'h33, 32'h23, 32'h33, 32'h33},
        '{32'h14, 32'h24, 32'h34, 1'b0, 1'b0, 1'b1, 32'h14, 32'h33, 32'h33, 32'h33},
        '{32'h15, 32'h25, 32'h35, 1'b1, 1'b1, 1'b1, 32'h35, 32'h35, 32'h35, 32'h35},
        '{32'h16, 32'h26, 32'h36, 1'b0, 1'b0, 1'b0, 32'h16, 32'h26, 32'h35, 32'h35},
        '{32'h17, 32'h27, 32'h37, 1'b0, 1'b0, 1'b0, 32'h17, 32'h27, 32'h16, 32'h16}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs are set at a falling edge; one rising edge; return at the next falling edge
    task automatic step(input logic ph);
        phase_b = ph;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic probe_window(input int a);
        kbus = 14'(a); c_vld = 1'b1; sel_r3b = 1'b1; cache_rdata = 32'(a) + 32'h1000;
        step(1'b1);
        c_vld = 1'b0; sel_r3b = 1'b0;
        chk("R8 c address capture", 64'(c_addr), 64'(a));
        step(1'b0);
        chk("R9 window strobe", 64'(wb_vld), 64'((a >= 96 && a < 112) ? 1 : 0));
        if (a >= 96 && a < 112)
            chk("R9 window data", 64'(wb_data), 64'(a + 'h1000));
        chk("R6 C load", 64'(creg), 64'(a + 'h1000));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 result2b", 64'(result2b), 0);
        chk("R1 result3a", 64'(result3a), 0);
        chk("R1 store3a", 64'(store3a), 0);
        chk("R1 result3b", 64'(result3b), 0);
        chk("R1 creg", 64'(creg), 0);
        chk("R1 wb_vld", 64'(wb_vld), 0);
        chk("R1 c_addr", 64'(c_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            // B phase: stage-2B and 3B sources valid; A-phase selects driven wrong on purpose
            alu_res = VEC[i].alu; store_op = VEC[i].st; cache_rdata = VEC[i].cache;
            sel_r3b = VEC[i].sr3b; sel_r3a = ~VEC[i].sr3a; sel_s3a = ~VEC[i].ss3a;
            step(1'b1);
            // A phase: B-phase inputs set to junk, must be ignored
            sel_r3a = VEC[i].sr3a; sel_s3a = VEC[i].ss3a;
            sel_r3b = ~VEC[i].sr3b; alu_res = 32'hEEEE; store_op = 32'hDDDD; cache_rdata = 32'hCCCC;
            step(1'b0);
            chk("R2 result2b", 64'(result2b), 64'(VEC[i].alu));
            chk("R3 result3a", 64'(result3a), 64'(VEC[i].e_r3a));
            chk("R4 store3a", 64'(store3a), 64'(VEC[i].e_s3a));
            chk("R5 result3b", 64'(result3b), 64'(VEC[i].e_r3b));
            chk("R6 creg", 64'(creg), 64'(VEC[i].e_c));
        end

        // R7: source address capture in B phase, ignored in A phase
        kbus = {7'd45, 7'd12}; ab_vld = 1'b1;
        step(1'b1);
        chk("R7 src_a", 64'(src_a), 12);
        chk("R7 src_b", 64'(src_b), 45);
        kbus = {7'd3, 7'd4};
        step(1'b0);
        chk("R7 src_a hold in A", 64'(src_a), 12);
        chk("R7 src_b hold in A", 64'(src_b), 45);
        ab_vld = 1'b0;
        step(1'b1);
        chk("R7 src_a hold no strobe", 64'(src_a), 12);

        // R9: window boundaries, strobe lasts one cycle
        probe_window(100);
        step(1'b1);
        chk("R9 strobe drops in B", 64'(wb_vld), 0);
        probe_window(95);
        probe_window(96);
        probe_window(111);
        probe_window(112);
        chk("R9 data held when outside", 64'(wb_data), 64'(111 + 'h1000));

        // R8: C strobe ignored in A phase
        kbus = 14'd7; c_vld = 1'b1;
        step(1'b0);
        c_vld = 1'b0;
        chk("R8 c_addr hold in A", 64'(c_addr), 112);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run result3a", 64'(result3a), 0);
        chk("R1 mid-run creg", 64'(creg), 0);
        chk("R1 mid-run src_a", 64'(src_a), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule